// File: doc/BRIEF.md
# On-Screen Caption Control Register Bank

This block sits behind a serial-bus byte decoder and holds the write-side register file of a caption and on-screen-display controller. A transaction begins with a start pulse that carries a 3-bit subaddress, followed by any number of data bytes. The same cycle as the start may also carry a data byte. Each byte is written to the register at the current subaddress. The subaddress then steps up by one until it reaches the character port, and it stays there for every further byte.

Two control bytes are decoded into named outputs:
- horizontal offset
- sync and video polarities
- field select
- display and enhanced-caption modes
- acquisition inhibit
- acquisition window width
- user channel
- a page-clear request

The page-clear request stays set until the display side pulses `clear_done`. A row pointer and a column pointer address the display memory. Each byte written to the character port produces a one-cycle memory write strobe. The strobe carries the pointer as it stood before the write and the low seven data bits. The column pointer then advances, and a column overflow carries into the row.

Top module: `osd_ctrl_regbank`

## Requirements
- R1: After reset every control output and both pointers are 0, `mem_we` is 0, and the subaddress is 0.
- R2: Subaddresses: 0 is control byte A, 1 is control byte B, 2 is the row, 3 is the column and 4 is the character port. Each data byte advances the subaddress by one. At 4 it stays at 4 until a new start is given.
- R3: A start with a subaddress above 4 selects subaddress 4. A data byte in the same cycle as a start is written to the new subaddress.
- R4: Control byte A decodes as follows: bits 3:0 give `h_offset`, bit 4 gives `vsync_pol`, bit 5 gives `hsync_pol`, bit 6 gives `video_pol` and bit 7 gives `field_sel`. Each output changes on the clock edge that takes the byte.
- R5: Control byte B decodes as follows: bits 1:0 give `disp_mode`, bits 3:2 give `caption_mode`, bit 4 gives `acq_inhibit`, bit 5 gives `wide_window` and bit 6 gives `user_chan`.
- R6: Bit 7 of control byte B sets `page_clear_req`. The request holds until a `clear_done` pulse clears it on the following edge. A write to control byte B in the same cycle as `clear_done` takes priority.
- R7: A write to subaddress 2 loads the row from data bits 3:0. A write to subaddress 3 loads the column from data bits 4:0. The upper bits are ignored, and neither write raises `mem_we`.
- R8: A write to subaddress 4 raises `mem_we` for exactly one cycle, on the edge that takes the byte. With it, `mem_row` and `mem_col` carry the pointers from before the write, and `mem_data` carries data bits 6:0. Bit 7 has no effect.
- R9: Each character write increments the column, which wraps from 31 to 0. On that wrap the row increments, and the row wraps from 15 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_start | input | 1 | Start of a transaction; loads the subaddress |
| wr_subaddr | input | 3 | Subaddress given with the start |
| wr_valid | input | 1 | Data byte present |
| wr_data | input | 8 | Data byte |
| clear_done | input | 1 | Pulse that ends a page clear |
| h_offset | output | 4 | Horizontal offset from sync |
| vsync_pol | output | 1 | Vertical sync polarity |
| hsync_pol | output | 1 | Horizontal sync polarity |
| video_pol | output | 1 | Video output polarity |
| field_sel | output | 1 | Field select (0 is field 1, 1 is field 2) |
| disp_mode | output | 2 | Display mode |
| caption_mode | output | 2 | Enhanced caption mode |
| acq_inhibit | output | 1 | Caption acquisition inhibited |
| wide_window | output | 1 | Scan lines 19 to 23 instead of line 21 only |
| user_chan | output | 1 | User channel select |
| page_clear_req | output | 1 | Page-memory clear request |
| row_ptr | output | 4 | Current row pointer |
| col_ptr | output | 5 | Current column pointer |
| mem_we | output | 1 | Display memory write strobe |
| mem_row | output | 4 | Row of the memory write |
| mem_col | output | 5 | Column of the memory write |
| mem_data | output | 7 | Character data of the memory write |

## Verification
Every result here lands on the clock edge that takes the byte: the decoded control fields, the pointer loads and increments, and the write strobe with its address and data. The clear of the page request lands on the edge that takes `clear_done`. The bench drives each byte at a falling edge and removes it after the next rising edge. It reads the outputs 2 ns after that rising edge, so each check sees exactly one cycle of latency. Idle cycles follow the strobe checks to confirm that `mem_we` has dropped and that `page_clear_req` holds until it is cleared.

// File: rtl/osd_regbank_pkg.sv
package osd_regbank_pkg;
    localparam int unsigned SUB_W  = 3;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned ROW_W  = 4;
    localparam int unsigned COL_W  = 5;
    localparam int unsigned CHAR_W = 7;
    localparam int unsigned HOFF_W = 4;
    localparam int unsigned NUM_REGS = 5;

    typedef enum logic [SUB_W-1:0] {
        SUB_CTRL_A = 3'd0,
        SUB_CTRL_B = 3'd1,
        SUB_ROW    = 3'd2,
        SUB_COL    = 3'd3,
        SUB_CHAR   = 3'd4
    } sub_e;

    typedef struct packed {
        logic [BYTE_W-1:0] ctrl_a;
        logic [BYTE_W-1:0] ctrl_b;
    } ctrl_state_t;

    typedef struct packed {
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic              we;
        logic [ROW_W-1:0]  we_row;
        logic [COL_W-1:0]  we_col;
        logic [CHAR_W-1:0] we_data;
    } ptr_state_t;
endpackage

// File: rtl/osd_subaddr_ctr.sv
module osd_subaddr_ctr
    import osd_regbank_pkg::*;
#(
    parameter int unsigned N_REGS = NUM_REGS,
    parameter int unsigned AW     = SUB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW-1:0]     start_sub,
    input  logic              byte_valid,
    output logic [AW-1:0]     eff_sub,
    output logic [N_REGS-1:0] sel
);
    localparam logic [AW-1:0] LAST = AW'(N_REGS - 1);

    logic [AW-1:0] sub_d, sub_q;
    logic [AW-1:0] start_clamped;

    always_comb begin
        start_clamped = (start_sub > LAST) ? LAST : start_sub;
        eff_sub       = start ? start_clamped : sub_q;
        sub_d         = eff_sub;
        if (byte_valid) begin
            sub_d = (eff_sub == LAST) ? LAST : eff_sub + AW'(1);
        end
    end

    for (genvar gi = 0; gi < N_REGS; gi++) begin : g_sel
        assign sel[gi] = byte_valid && (eff_sub == AW'(gi));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sub_q <= '0;
        else        sub_q <= sub_d;
    end
endmodule

// File: rtl/osd_ctrl_bytes.sv
module osd_ctrl_bytes
    import osd_regbank_pkg::*;
#(
    parameter int unsigned DW = BYTE_W,
    parameter int unsigned HW = HOFF_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_a,
    input  logic          wr_b,
    input  logic [DW-1:0] data,
    input  logic          clear_done,
    output logic [HW-1:0] h_offset,
    output logic          vsync_pol,
    output logic          hsync_pol,
    output logic          video_pol,
    output logic          field_sel,
    output logic [1:0]    disp_mode,
    output logic [1:0]    caption_mode,
    output logic          acq_inhibit,
    output logic          wide_window,
    output logic          user_chan,
    output logic          page_clear_req
);
    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_a) st_d.ctrl_a = data;
        if (wr_b) begin
            st_d.ctrl_b = data;
        end else if (clear_done) begin
            st_d.ctrl_b[7] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign h_offset       = st_q.ctrl_a[HW-1:0];
    assign vsync_pol      = st_q.ctrl_a[4];
    assign hsync_pol      = st_q.ctrl_a[5];
    assign video_pol      = st_q.ctrl_a[6];
    assign field_sel      = st_q.ctrl_a[7];
    assign disp_mode      = st_q.ctrl_b[1:0];
    assign caption_mode   = st_q.ctrl_b[3:2];
    assign acq_inhibit    = st_q.ctrl_b[4];
    assign wide_window    = st_q.ctrl_b[5];
    assign user_chan      = st_q.ctrl_b[6];
    assign page_clear_req = st_q.ctrl_b[7];
endmodule

// File: rtl/osd_pointer.sv
module osd_pointer
    import osd_regbank_pkg::*;
#(
    parameter int unsigned DW = BYTE_W,
    parameter int unsigned RW = ROW_W,
    parameter int unsigned CW = COL_W,
    parameter int unsigned XW = CHAR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_row,
    input  logic          ld_col,
    input  logic          wr_char,
    input  logic [DW-1:0] data,
    output logic [RW-1:0] row_ptr,
    output logic [CW-1:0] col_ptr,
    output logic          mem_we,
    output logic [RW-1:0] mem_row,
    output logic [CW-1:0] mem_col,
    output logic [XW-1:0] mem_data
);
    localparam logic [CW-1:0] COL_MAX = {CW{1'b1}};

    ptr_state_t st_d, st_q;
    logic       col_wrap;

    always_comb begin
        st_d     = st_q;
        st_d.we  = 1'b0;
        col_wrap = (st_q.col == COL_MAX);
        if (wr_char) begin
            st_d.we      = 1'b1;
            st_d.we_row  = st_q.row;
            st_d.we_col  = st_q.col;
            st_d.we_data = data[XW-1:0];
            st_d.col     = st_q.col + CW'(1);
            if (col_wrap) st_d.row = st_q.row + RW'(1);
        end
        if (ld_row) st_d.row = data[RW-1:0];
        if (ld_col) st_d.col = data[CW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign row_ptr  = st_q.row;
    assign col_ptr  = st_q.col;
    assign mem_we   = st_q.we;
    assign mem_row  = st_q.we_row;
    assign mem_col  = st_q.we_col;
    assign mem_data = st_q.we_data;
endmodule

// File: rtl/osd_ctrl_regbank.sv
module osd_ctrl_regbank
    import osd_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start,
    input  logic [SUB_W-1:0]  wr_subaddr,
    input  logic              wr_valid,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              clear_done,
    output logic [HOFF_W-1:0] h_offset,
    output logic              vsync_pol,
    output logic              hsync_pol,
    output logic              video_pol,
    output logic              field_sel,
    output logic [1:0]        disp_mode,
    output logic [1:0]        caption_mode,
    output logic              acq_inhibit,
    output logic              wide_window,
    output logic              user_chan,
    output logic              page_clear_req,
    output logic [ROW_W-1:0]  row_ptr,
    output logic [COL_W-1:0]  col_ptr,
    output logic              mem_we,
    output logic [ROW_W-1:0]  mem_row,
    output logic [COL_W-1:0]  mem_col,
    output logic [CHAR_W-1:0] mem_data
);
    logic [SUB_W-1:0]    eff_sub;
    logic [NUM_REGS-1:0] sel;

    osd_subaddr_ctr #(.N_REGS(NUM_REGS), .AW(SUB_W)) u_sub (
        .clk(clk), .rst_n(rst_n), .start(wr_start), .start_sub(wr_subaddr),
        .byte_valid(wr_valid), .eff_sub(eff_sub), .sel(sel)
    );

    osd_ctrl_bytes #(.DW(BYTE_W), .HW(HOFF_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_a(sel[SUB_CTRL_A]), .wr_b(sel[SUB_CTRL_B]),
        .data(wr_data), .clear_done(clear_done),
        .h_offset(h_offset), .vsync_pol(vsync_pol), .hsync_pol(hsync_pol),
        .video_pol(video_pol), .field_sel(field_sel), .disp_mode(disp_mode),
        .caption_mode(caption_mode), .acq_inhibit(acq_inhibit),
        .wide_window(wide_window), .user_chan(user_chan),
        .page_clear_req(page_clear_req)
    );

    osd_pointer #(.DW(BYTE_W), .RW(ROW_W), .CW(COL_W), .XW(CHAR_W)) u_ptr (
        .clk(clk), .rst_n(rst_n),
        .ld_row(sel[SUB_ROW]), .ld_col(sel[SUB_COL]), .wr_char(sel[SUB_CHAR]),
        .data(wr_data),
        .row_ptr(row_ptr), .col_ptr(col_ptr),
        .mem_we(mem_we), .mem_row(mem_row), .mem_col(mem_col), .mem_data(mem_data)
    );
endmodule

// File: rtl/osd_regbank_checker.sv
module osd_regbank_checker
    import osd_regbank_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic              wr_start,
    input logic [SUB_W-1:0]  eff_sub,
    input logic [BYTE_W-1:0] wr_data,
    input logic              clear_done,
    input logic              page_clear_req,
    input logic [ROW_W-1:0]  row_ptr,
    input logic [COL_W-1:0]  col_ptr,
    input logic              mem_we,
    input logic [ROW_W-1:0]  mem_row,
    input logic [COL_W-1:0]  mem_col,
    input logic [CHAR_W-1:0] mem_data
);
    logic char_wr;
    assign char_wr = wr_valid && (eff_sub == SUB_CHAR);

    assert_sub_saturates_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (char_wr && !wr_start) ##1 (!wr_start) |-> (eff_sub == SUB_CHAR));

    assert_sub_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        eff_sub <= SUB_CHAR);

    assert_strobe_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        char_wr |=> (mem_we && mem_row == $past(row_ptr) && mem_col == $past(col_ptr)
                     && mem_data == $past(wr_data[CHAR_W-1:0])));

    assert_no_stray_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !char_wr |=> !mem_we);

    assert_col_advance_R9: assert property (@(posedge clk) disable iff (!rst_n)
        char_wr |=> (col_ptr == $past(col_ptr) + COL_W'(1)));

    assert_row_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (char_wr && col_ptr == {COL_W{1'b1}}) |=> (row_ptr == $past(row_ptr) + ROW_W'(1)));

    assert_clear_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_done && !(wr_valid && eff_sub == SUB_CTRL_B)) |=> !page_clear_req);
endmodule

bind osd_ctrl_regbank osd_regbank_checker u_chk (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_start(wr_start),
    .eff_sub(eff_sub), .wr_data(wr_data), .clear_done(clear_done),
    .page_clear_req(page_clear_req), .row_ptr(row_ptr), .col_ptr(col_ptr),
    .mem_we(mem_we), .mem_row(mem_row), .mem_col(mem_col), .mem_data(mem_data)
);

// File: tb/tb_osd_ctrl_regbank.sv
module tb_osd_ctrl_regbank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_start = 1'b0;
    logic [2:0] wr_subaddr = '0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       clear_done = 1'b0;
    logic [3:0] h_offset;
    logic       vsync_pol, hsync_pol, video_pol, field_sel;
    logic [1:0] disp_mode, caption_mode;
    logic       acq_inhibit, wide_window, user_chan, page_clear_req;
    logic [3:0] row_ptr;
    logic [4:0] col_ptr;
    logic       mem_we;
    logic [3:0] mem_row;
    logic [4:0] mem_col;
    logic [6:0] mem_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    osd_ctrl_regbank dut (
        .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_subaddr(wr_subaddr),
        .wr_valid(wr_valid), .wr_data(wr_data), .clear_done(clear_done),
        .h_offset(h_offset), .vsync_pol(vsync_pol), .hsync_pol(hsync_pol),
        .video_pol(video_pol), .field_sel(field_sel), .disp_mode(disp_mode),
        .caption_mode(caption_mode), .acq_inhibit(acq_inhibit),
        .wide_window(wide_window), .user_chan(user_chan),
        .page_clear_req(page_clear_req), .row_ptr(row_ptr), .col_ptr(col_ptr),
        .mem_we(mem_we), .mem_row(mem_row), .mem_col(mem_col), .mem_data(mem_data)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle of stimulus; outputs are read 2 ns after the taking edge.
    task automatic cycle(bit st, logic [2:0] sub, bit v, logic [7:0] d, bit cd);
        @(negedge clk);
        wr_start = st; wr_subaddr = sub; wr_valid = v; wr_data = d; clear_done = cd;
        @(posedge clk);
        #2;
        wr_start = 1'b0; wr_valid = 1'b0; clear_done = 1'b0;
    endtask

    task automatic expect_strobe(string req, logic [3:0] r, logic [4:0] c, logic [6:0] d);
        check(req, {31'd0, mem_we}, 32'd1);
        check(req, {28'd0, mem_row}, {28'd0, r});
        check(req, {27'd0, mem_col}, {27'd0, c});
        check(req, {25'd0, mem_data}, {25'd0, d});
    endtask

    task automatic t_reset();
        check("R1", {28'd0, h_offset}, 0);
        check("R1", {27'd0, field_sel, video_pol, hsync_pol, vsync_pol, page_clear_req}, 0);
        check("R1", {26'd0, disp_mode, caption_mode, acq_inhibit, wide_window}, 0);
        check("R1", {23'd0, row_ptr, col_ptr}, 0);
        check("R1", {31'd0, mem_we}, 0);
    endtask

    task automatic t_auto_increment();
        cycle(1, 3'd0, 1, 8'hA5, 0);          // R4
        check("R4", {28'd0, h_offset}, 5);
        check("R4", {28'd0, field_sel, video_pol, hsync_pol, vsync_pol}, 4'b1010);
        check("R7", {31'd0, mem_we}, 0);
        cycle(0, 3'd0, 1, 8'h3C, 0);          // R2 advance to ctrl B, R5
        check("R5", {28'd0, caption_mode, disp_mode}, 4'b1100);
        check("R5", {29'd0, user_chan, wide_window, acq_inhibit}, 3'b011);
        check("R6", {31'd0, page_clear_req}, 0);
        check("R4", {28'd0, h_offset}, 5);
        cycle(0, 3'd0, 1, 8'hF7, 0);          // R7 row load, upper bits ignored
        check("R7", {28'd0, row_ptr}, 7);
        check("R7", {31'd0, mem_we}, 0);
        cycle(0, 3'd0, 1, 8'hFE, 0);          // R7 col load
        check("R7", {27'd0, col_ptr}, 30);
        check("R7", {31'd0, mem_we}, 0);
        cycle(0, 3'd0, 1, 8'h41, 0);          // R8
        expect_strobe("R8", 4'd7, 5'd30, 7'h41);
        check("R9", {27'd0, col_ptr}, 31);
        cycle(0, 3'd0, 1, 8'hC2, 0);          // R2 stays at 4, R8 bit7 ignored, R9 carry
        expect_strobe("R2", 4'd7, 5'd31, 7'h42);
        check("R9", {23'd0, row_ptr, col_ptr}, {23'd0, 4'd8, 5'd0});
        cycle(0, 3'd0, 0, 8'h00, 0);          // R8 single cycle
        check("R8", {31'd0, mem_we}, 0);
        check("R4", {28'd0, field_sel, video_pol, hsync_pol, vsync_pol}, 4'b1010);
    endtask

    task automatic t_row_wrap();
        cycle(1, 3'd2, 1, 8'h0F, 0);
        cycle(0, 3'd0, 1, 8'h1F, 0);
        check("R7", {23'd0, row_ptr, col_ptr}, {23'd0, 4'd15, 5'd31});
        cycle(0, 3'd0, 1, 8'h55, 0);
        expect_strobe("R9", 4'd15, 5'd31, 7'h55);
        check("R9", {23'd0, row_ptr, col_ptr}, 0);
    endtask

    task automatic t_clamp();
        cycle(1, 3'd6, 1, 8'h11, 0);          // R3 clamp + same-cycle data
        expect_strobe("R3", 4'd0, 5'd0, 7'h11);
        check("R3", {27'd0, col_ptr}, 1);
        check("R4", {28'd0, h_offset}, 5);
    endtask

    task automatic t_page_clear();
        cycle(1, 3'd1, 1, 8'h80, 0);
        check("R6", {31'd0, page_clear_req}, 1);
        check("R5", {26'd0, disp_mode, caption_mode, acq_inhibit, wide_window}, 0);
        repeat (4) cycle(0, 3'd0, 0, 8'h00, 0);
        check("R6", {31'd0, page_clear_req}, 1);
        cycle(0, 3'd0, 0, 8'h00, 1);
        check("R6", {31'd0, page_clear_req}, 0);
        cycle(1, 3'd1, 1, 8'h80, 1);          // write wins over clear_done
        check("R6", {31'd0, page_clear_req}, 1);
        cycle(0, 3'd0, 0, 8'h00, 1);
        check("R6", {31'd0, page_clear_req}, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_auto_increment();
        t_row_wrap();
        t_clamp();
        t_page_clear();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule